// File: doc/BRIEF.md
# Decade Autoranging Range Controller

This block chooses the measurement range of a current meter in decade steps. A counter of three bits holds the selected range. Code 0 is the least sensitive range (full scale 10^-2 A) and code 7 is the most sensitive (10^-9 A). The converter raises a one-cycle store strobe when a new four-digit BCD reading is ready. The controller latches that reading, waits a programmable settling time, and then classifies it. A reading below 0100 moves the range one decade more sensitive. A reading above 1999 sends it back to code 0, and later readings step it down again from there. Ranging therefore only ever moves toward more sensitive ranges, except when it resets.

A hold-mode input freezes the range completely. The zero-check and remote range-hold inputs block only the automatic decisions. An operator can step the range with a momentary press input, which wraps from 7 back to 0. A level reset input pins the range at code 0 while it is asserted. The outputs are the range index, a registered BCD exponent digit, and a flag that marks readings as invalid while ranging is still in progress.

Top module: `decade_range_ctrl`

## Requirements
- R1: After a synchronous active-low reset, range_idx is 0, exp_digit is 2 and ranging is 0.
- R2: A decision on a reading whose thousands and hundreds digits are both 0 (below 0100) raises range_idx by one and sets ranging. At range 7 it leaves the range unchanged and clears ranging.
- R3: A decision on a reading whose thousands digit is 2 or more (above 1999) sets range_idx to 0 and sets ranging. At range 0 it leaves the range at 0 and clears ranging.
- R4: While hold_mode is 1, range_idx does not change: decisions, presses and reset_ctl are all ignored.
- R5: While zero_chk or range_hold is 1, decisions do not change range_idx. Presses and reset_ctl still act.
- R6: Each rising edge of step_press raises range_idx by one, however long the press is held. From 7 it wraps to 0.
- R7: While reset_ctl is 1 (and hold_mode is 0), range_idx is 0. This takes priority over presses and decisions.
- R8: exp_digit is the BCD digit range_idx+2 (2..9), registered one cycle behind range_idx.
- R9: The reading is latched on the cycle store_evt is 1. The decision takes effect SETTLE_CYC clock edges after that edge, using the latched value. A new store_evt restarts the wait.
- R10: A decision on a reading from 0100 to 1999 leaves range_idx unchanged and clears ranging. A decision that is inhibited by R4 or R5 also clears ranging. Presses and reset_ctl do not alter ranging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| store_evt | input | 1 | One-cycle strobe: new reading ready |
| reading_bcd | input | 16 | Four BCD digits, thousands in [15:12], units in [3:0] |
| hold_mode | input | 1 | Freeze range entirely |
| zero_chk | input | 1 | Zero-check active; inhibits automatic ranging |
| range_hold | input | 1 | Remote range hold; inhibits automatic ranging |
| step_press | input | 1 | Momentary press: one step more sensitive |
| reset_ctl | input | 1 | Level: force range 0 while high |
| range_idx | output | 3 | Selected range, 0 = 10^-2 A, 7 = 10^-9 A |
| exp_digit | output | 4 | BCD exponent digit of the range |
| ranging | output | 1 | High while automatic range changes are in progress |

## Verification
Random readings are drawn from three classes: under-range, in-range and over-range. They are mixed with random hold, zero-check and remote-hold levels, so that stepping, resetting, keeping the range and inhibition are each told apart. Directed cases cover the two edge ranges: an under-range reading at range 7 and an over-range reading at range 0 must both leave the range unchanged and clear the flag. They also cover press wrap-around and a long press that must give only one step. Further directed cases check reset_ctl priority, and a reading changed after the strobe, which shows that the latched value is used and that nothing changes one cycle before the settling time ends.

// File: rtl/decade_pkg.sv
// Shared types and constants for the decade range controller.
package decade_pkg;
    typedef logic [2:0]  range_t;
    typedef logic [15:0] bcd4_t;
    localparam range_t RANGE_LEAST = 3'd0;
    localparam range_t RANGE_MOST  = 3'd7;
    localparam logic [3:0] EXP_OFFSET = 4'd2;
endpackage

// File: rtl/rng_reading_class.sv
// Classifies a four-digit BCD reading as under-range (<0100) or
// over-range (>1999). Assumes every digit is valid BCD.
module rng_reading_class
    import decade_pkg::*;
(
    input  bcd4_t reading,
    output logic  under,
    output logic  over
);
    // Combinational decode of the two leading digits.
    always_comb begin
        under = (reading[15:12] == 4'd0) && (reading[11:8] == 4'd0);
        over  = (reading[15:12] >= 4'd2);
    end
endmodule

// File: rtl/rng_settle_timer.sv
// Latches the reading on a store strobe and fires a one-cycle decision
// pulse SETTLE_CYC edges later. A new strobe restarts the wait.
// Assumes SETTLE_CYC >= 1.
module rng_settle_timer
    import decade_pkg::*;
#(
    parameter int SETTLE_CYC = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  store_evt,
    input  bcd4_t reading_in,
    output bcd4_t reading_lat,
    output logic  fire
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_q;

    // Load the countdown and capture data on a strobe, else count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            reading_lat <= '0;
        end else if (store_evt) begin
            cnt_q       <= LOAD;
            reading_lat <= reading_in;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Decision pulse in the last cycle of the countdown.
    always_comb fire = (cnt_q == CW'(1));

    AST_FIRE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt_q == '0) || $past(store_evt)); // R9
endmodule

// File: rtl/rng_press_edge.sv
// Rising-edge detector for the momentary step input; one press, one pulse.
module rng_press_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic press,
    output logic edge_p
);
    logic prev_q;

    // Remember the previous press level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= press;
    end

    // Pulse on a 0 -> 1 transition.
    always_comb edge_p = press && !prev_q;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_p |=> !edge_p); // R6
endmodule

// File: rtl/rng_step_core.sv
// Range counter and ranging flag. Priority: hold, reset, press, decision.
// Assumes fire and press_edge are single-cycle pulses.
module rng_step_core
    import decade_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hold_mode,
    input  logic   auto_inh,
    input  logic   reset_ctl,
    input  logic   press_edge,
    input  logic   fire,
    input  logic   under,
    input  logic   over,
    output range_t range_q,
    output logic   flag_q
);
    // Update the range and flag according to the priority above.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= RANGE_LEAST;
            flag_q  <= 1'b0;
        end else if (hold_mode) begin
            if (fire) flag_q <= 1'b0;
        end else if (reset_ctl) begin
            range_q <= RANGE_LEAST;
        end else if (press_edge) begin
            range_q <= range_q + 3'd1;
        end else if (fire) begin
            if (auto_inh) begin
                flag_q <= 1'b0;
            end else if (over && range_q != RANGE_LEAST) begin
                range_q <= RANGE_LEAST;
                flag_q  <= 1'b1;
            end else if (under && !over && range_q != RANGE_MOST) begin
                range_q <= range_q + 3'd1;
                flag_q  <= 1'b1;
            end else begin
                flag_q <= 1'b0;
            end
        end
    end

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_mode |=> $stable(range_q)); // R4
    AST_RESET_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_ctl && !hold_mode) |=> (range_q == RANGE_LEAST)); // R7
    AST_PRESS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (press_edge && !hold_mode && !reset_ctl && range_q == RANGE_MOST)
        |=> (range_q == RANGE_LEAST)); // R6
    AST_OVER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && over && !auto_inh && !hold_mode && !reset_ctl && !press_edge)
        |=> (range_q == RANGE_LEAST)); // R3
    AST_INHIBIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && auto_inh && !hold_mode && !reset_ctl && !press_edge)
        |=> ($stable(range_q) && !flag_q)); // R5
endmodule

// File: rtl/decade_range_ctrl.sv
// Top of the decade autoranging controller: settle timer, reading
// classifier, press edge detector, range core and exponent register.
module decade_range_ctrl
    import decade_pkg::*;
#(
    parameter int SETTLE_CYC = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        store_evt,
    input  logic [15:0] reading_bcd,
    input  logic        hold_mode,
    input  logic        zero_chk,
    input  logic        range_hold,
    input  logic        step_press,
    input  logic        reset_ctl,
    output logic [2:0]  range_idx,
    output logic [3:0]  exp_digit,
    output logic        ranging
);
    bcd4_t  lat_rd;
    logic   fire, under, over, press_edge;
    range_t range_q;
    logic   flag_q;
    logic [3:0] exp_q;

    rng_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .store_evt(store_evt),
        .reading_in(reading_bcd), .reading_lat(lat_rd), .fire(fire)
    );

    rng_reading_class u_class (
        .reading(lat_rd), .under(under), .over(over)
    );

    rng_press_edge u_press (
        .clk(clk), .rst_n(rst_n), .press(step_press), .edge_p(press_edge)
    );

    rng_step_core u_core (
        .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode),
        .auto_inh(zero_chk || range_hold), .reset_ctl(reset_ctl),
        .press_edge(press_edge), .fire(fire), .under(under), .over(over),
        .range_q(range_q), .flag_q(flag_q)
    );

    // Separate output register holding the BCD exponent of the range.
    always_ff @(posedge clk) begin
        if (!rst_n) exp_q <= EXP_OFFSET;
        else        exp_q <= {1'b0, range_q} + EXP_OFFSET;
    end

    always_comb begin
        range_idx = range_q;
        exp_digit = exp_q;
        ranging   = flag_q;
    end

    AST_EXP_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (exp_digit == {1'b0, $past(range_idx)} + 4'd2)); // R8
endmodule

// File: tb/sim_decade_range_ctrl.sv
module sim_decade_range_ctrl;
    localparam int S = 6;

    logic clk = 0, rst_n = 0;
    logic store_evt = 0, hold_mode = 0, zero_chk = 0, range_hold = 0;
    logic step_press = 0, reset_ctl = 0;
    logic [15:0] reading_bcd = 0;
    logic [2:0] range_idx;
    logic [3:0] exp_digit;
    logic ranging;

    int n_chk = 0, n_bad = 0;
    int m_rng = 0;
    bit m_flag = 0;
    bit done = 0;

    always #2 clk = ~clk;

    decade_range_ctrl #(.SETTLE_CYC(S)) u0 (
        .clk(clk), .rst_n(rst_n), .store_evt(store_evt),
        .reading_bcd(reading_bcd), .hold_mode(hold_mode),
        .zero_chk(zero_chk), .range_hold(range_hold),
        .step_press(step_press), .reset_ctl(reset_ctl),
        .range_idx(range_idx), .exp_digit(exp_digit), .ranging(ranging)
    );

    function automatic bit f_under(logic [15:0] r);
        return r[15:12] == 0 && r[11:8] == 0;
    endfunction
    function automatic bit f_over(logic [15:0] r);
        return r[15:12] >= 2;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk(req, range_idx, m_rng);
        chk(req, ranging, m_flag);
        chk("R8", exp_digit, m_rng + 2);
    endtask

    function automatic logic [15:0] rnd_reading(int cls);
        logic [15:0] r;
        r[7:4] = 4'($urandom % 10);
        r[3:0] = 4'($urandom % 10);
        if (cls == 0) r[15:8] = 8'h00;
        else if (cls == 1) begin
            if ($urandom % 2 == 0) begin
                r[15:12] = 4'd0;
                r[11:8]  = 4'(1 + $urandom % 9);
            end else begin
                r[15:12] = 4'd1;
                r[11:8]  = 4'($urandom % 10);
            end
        end else begin
            r[15:12] = 4'(2 + $urandom % 8);
            r[11:8]  = 4'($urandom % 10);
        end
        return r;
    endfunction

    // Model of one decision (R2, R3, R4, R5, R10).
    task automatic model_decide(logic [15:0] r);
        if (hold_mode || zero_chk || range_hold) m_flag = 0;
        else if (f_over(r)) begin
            if (m_rng != 0) begin m_rng = 0; m_flag = 1; end else m_flag = 0;
        end else if (f_under(r)) begin
            if (m_rng != 7) begin m_rng++; m_flag = 1; end else m_flag = 0;
        end else m_flag = 0;
    endtask

    task automatic do_store(logic [15:0] r);
        reading_bcd = r;
        store_evt = 1;
        @(negedge clk);
        store_evt = 0;
        repeat (S + 1) @(negedge clk);
        model_decide(r);
    endtask

    task automatic do_press(int len);
        step_press = 1;
        repeat (len) @(negedge clk);
        step_press = 0;
        @(negedge clk);
        if (!hold_mode) m_rng = (m_rng + 1) % 8;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_all("R1");

        // R6: long press gives one step; wrap 7 -> 0
        do_press(5); chk_all("R6");
        for (int i = 0; i < 6; i++) do_press(1);
        chk_all("R6");
        do_press(2); chk_all("R6 wrap");

        // R2: under-range steps; at 7 no move, flag cleared
        for (int i = 0; i < 8; i++) begin
            do_store(16'h0042); chk_all("R2");
        end
        // R3 / R10: in-range keeps range
        do_store(16'h1234); chk_all("R10");
        do_store(16'h2500); chk_all("R3");
        do_store(16'h7000); chk_all("R3 at 0");

        // R9: reading latched; no change one cycle early
        do_press(1); do_press(1);
        reading_bcd = 16'h0007; store_evt = 1;
        @(negedge clk);
        store_evt = 0; reading_bcd = 16'h9999;
        repeat (S - 1) @(negedge clk);
        chk("R9 early", range_idx, m_rng);
        @(negedge clk); @(negedge clk);
        model_decide(16'h0007);
        chk_all("R9 latch");

        // R7: reset_ctl forces 0 and beats a press and a decision
        reset_ctl = 1; reading_bcd = 16'h0001; store_evt = 1;
        @(negedge clk);
        store_evt = 0; step_press = 1;
        repeat (S + 1) @(negedge clk);
        m_rng = 0;
        chk("R7", range_idx, 0);
        chk("R10 reset keeps flag", ranging, m_flag);
        reset_ctl = 0; step_press = 0;
        @(negedge clk); chk_all("R7 release");

        // R4: hold ignores press and reset
        do_press(1); do_press(1);
        hold_mode = 1;
        do_press(1); chk_all("R4 press");
        reset_ctl = 1; repeat (3) @(negedge clk); reset_ctl = 0;
        @(negedge clk); chk_all("R4 reset");
        do_store(16'h3000); chk_all("R4 auto");
        hold_mode = 0;

        // R5: zero check inhibits auto, not presses
        zero_chk = 1;
        do_store(16'h0000); chk_all("R5 auto");
        do_press(1); chk_all("R5 press");
        zero_chk = 0;

        // Random mix
        for (int i = 0; i < 300; i++) begin
            hold_mode  = ($urandom % 6 == 0);
            zero_chk   = ($urandom % 8 == 0);
            range_hold = ($urandom % 8 == 0);
            if ($urandom % 5 == 0) begin
                do_press(1 + $urandom % 3); chk_all("R6 rnd");
            end else begin
                do_store(rnd_reading($urandom % 3)); chk_all("R2 R3 R5 rnd");
            end
        end
        done = 1;
    end

    initial begin
        process::self().srandom(32'h5eed_0445);
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule